// File: doc/BRIEF.md
# Signed Crossbar Tile Accumulator

This block is one compute tile of a neuromorphic fabric. Each read step it takes eight 4-bit activation levels and an 8x8 matrix of sign-magnitude 5-bit weights, and forms eight signed row products in a single cycle. The sum of all rows is added to a signed 16-bit potential. The potential then decays toward zero by a programmable amount without ever changing sign. A window test on the new potential produces a pending lock flag, which the tile commits to its lock register only when the write-phase strobe arrives.

Alongside the potential path, every row sum is rounded up by one eighth and clamped to a 4-bit level. The resulting eight-lane drive vector feeds a shared output bus, and it is forced to zero when bus reading is disabled. An ACTIVE permission input gates the tile: while it is low, the potential, both lock flags and the drive vector are held at zero. The surrounding controller pulses the read strobe once per step and the write strobe once per commit.

Top module: `crossbar_tile`

## Requirements
- R1: Lane k of `lanes_i` sits at bits 4k+3..4k and is an unsigned level 0..15. The weight for row r and input i sits at bits 5(8r+i)+4..5(8r+i) of `weights_i`. Its bits 2..0 are the magnitude, bit 3 set means positive and clear means negative, and bit 4 has no effect.
- R2: Each row sum is the sum over the inputs of level times weight. On every read strobe with ACTIVE high, the total of all eight row sums is added to the potential.
- R3: The addition saturates at +32767 and -32768 and never wraps.
- R4: After the addition, a positive potential drops by `decay_i` and a negative potential rises by `decay_i`, stopping at 0 in both cases. This decay also applies while the tile is locked.
- R5: Within one read step the order is fixed: add the total, then apply decay, then run the lock test on the decayed value.
- R6: The pending lock is set when thr_lo <= potential <= thr_hi, with both bounds inclusive. If the two thresholds are equal, the pending lock is always 0.
- R7: Drive lane r becomes min(15, (max(row_sum_r, 0) + 7) >> 3) at each read strobe. Lane r sits at bits 4r+3..4r of `drive_o`.
- R8: A read strobe with `bus_r_i` low loads an all-zero drive vector, while the potential still updates.
- R9: While ACTIVE is low, the potential, pending lock, committed lock and drive vector are all 0 after the next clock, whatever the strobes do.
- R10: The committed lock copies the pending lock only on a write strobe, and holds its value otherwise.
- R11: `bus_en_o` is high exactly when `bus_w_i` is high and the committed lock is set.
- R12: Without a read strobe, the potential, pending lock and drive vector hold their values even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| active_i | input | 1 | Compute permission; low clears the tile state |
| rd_stb_i | input | 1 | Read-phase step strobe |
| wr_stb_i | input | 1 | Write-phase commit strobe |
| lanes_i | input | 32 | Eight 4-bit activation levels |
| weights_i | input | 320 | 64 sign-magnitude 5-bit weights |
| thr_lo_i | input | 16 | Signed lower lock bound |
| thr_hi_i | input | 16 | Signed upper lock bound |
| decay_i | input | 16 | Unsigned decay step |
| bus_r_i | input | 1 | Enables the drive vector |
| bus_w_i | input | 1 | Enables bus output when locked |
| locked_o | output | 1 | Committed lock |
| lock_next_o | output | 1 | Pending lock from the last read step |
| bus_en_o | output | 1 | Bus drive enable |
| drive_o | output | 32 | Eight 4-bit drive levels |
| potential_o | output | 16 | Signed potential |

## Verification
The bench builds the tile with its default parameters: eight lanes, 4-bit levels, 3-bit magnitudes and a 16-bit potential. With these values, full-scale weights and inputs reach either saturation limit within five read steps. They also put every rounding boundary of the drive quantizer (sums of 8, 9, 120 and 121) within reach of a single weight pattern. A small decay against a known sum tells add-then-decay apart from decay-then-add, and the lock window edges can be hit exactly from both sides.

// File: rtl/tile_pkg.sv
`timescale 1ns/1ps
package tile_pkg;

  // Signed product of one level and one sign-magnitude weight code.
  function automatic int cell_product(input int level, input int wcode, input int mag_w);
    int mag;
    mag = wcode & ((1 << mag_w) - 1);
    if (((wcode >> mag_w) & 1) != 0) return level * mag;
    return -(level * mag);
  endfunction

  // Clamp an integer into [lo, hi].
  function automatic int sat_to(input int v, input int lo, input int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Move v toward zero by d without crossing zero.
  function automatic int decay_toward_zero(input int v, input int d);
    if (v > 0) return (v > d) ? v - d : 0;
    if (v < 0) return (-v > d) ? v + d : 0;
    return 0;
  endfunction

  // Round-up scale and clamp of a signed row sum to an output level.
  function automatic int level_from_row(input int s, input int shift, input int maxv);
    int q;
    if (s <= 0) return 0;
    q = (s + (1 << shift) - 1) >>> shift;
    return (q > maxv) ? maxv : q;
  endfunction

  // Inclusive window test; an empty window (lo == hi) never matches.
  function automatic logic in_window(input int v, input int lo, input int hi);
    return (lo != hi) && (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/tile_xbar.sv
`timescale 1ns/1ps
module tile_xbar #(
  parameter int LANES = 8,
  parameter int LVL_W = 4,
  parameter int MAG_W = 3,
  parameter int WGT_W = MAG_W + 2,
  parameter int ROW_W = LVL_W + MAG_W + $clog2(LANES) + 1,
  parameter int TOT_W = ROW_W + $clog2(LANES)
) (
  input  logic [LANES*LVL_W-1:0]       lanes_i,
  input  logic [LANES*LANES*WGT_W-1:0] wts_i,
  output logic [LANES*ROW_W-1:0]       rows_o,
  output logic signed [TOT_W-1:0]      total_o
);

  for (genvar r = 0; r < LANES; r++) begin : g_row
    int acc;
    always_comb begin
      acc = 0;
      for (int i = 0; i < LANES; i++) begin
        acc += tile_pkg::cell_product(int'(lanes_i[i*LVL_W +: LVL_W]),
                                      int'(wts_i[(r*LANES+i)*WGT_W +: WGT_W]),
                                      MAG_W);
      end
    end
    assign rows_o[r*ROW_W +: ROW_W] = ROW_W'(acc);
  end

  int tot;
  always_comb begin
    tot = 0;
    for (int r = 0; r < LANES; r++) begin
      tot += int'($signed(rows_o[r*ROW_W +: ROW_W]));
    end
  end
  assign total_o = TOT_W'(tot);

endmodule

// File: rtl/tile_quant.sv
`timescale 1ns/1ps
module tile_quant #(
  parameter int LANES = 8,
  parameter int LVL_W = 4,
  parameter int ROW_W = 11
) (
  input  logic [LANES*ROW_W-1:0] rows_i,
  output logic [LANES*LVL_W-1:0] levels_o
);

  localparam int SHIFT = $clog2(LANES);
  localparam int MAXV  = (1 << LVL_W) - 1;

  for (genvar r = 0; r < LANES; r++) begin : g_lane
    assign levels_o[r*LVL_W +: LVL_W] =
      LVL_W'(tile_pkg::level_from_row(int'($signed(rows_i[r*ROW_W +: ROW_W])), SHIFT, MAXV));
  end

endmodule

// File: rtl/tile_potential.sv
`timescale 1ns/1ps
module tile_potential #(
  parameter int ACC_W = 16,
  parameter int TOT_W = 14,
  parameter int DEC_W = 16
) (
  input  logic signed [ACC_W-1:0] pot_i,
  input  logic signed [TOT_W-1:0] total_i,
  input  logic        [DEC_W-1:0] decay_i,
  output logic signed [ACC_W-1:0] summed_o,
  output logic signed [ACC_W-1:0] next_o
);

  localparam int ACC_MAX = (1 << (ACC_W - 1)) - 1;
  localparam int ACC_MIN = -ACC_MAX - 1;

  int sum_sat;
  int after_decay;

  always_comb begin
    sum_sat     = tile_pkg::sat_to(int'(pot_i) + int'(total_i), ACC_MIN, ACC_MAX);
    after_decay = tile_pkg::decay_toward_zero(sum_sat, int'(decay_i));
  end

  assign summed_o = ACC_W'(sum_sat);
  assign next_o   = ACC_W'(after_decay);

endmodule

// File: rtl/crossbar_tile.sv
`timescale 1ns/1ps
module crossbar_tile #(
  parameter int LANES = 8,
  parameter int LVL_W = 4,
  parameter int MAG_W = 3,
  parameter int ACC_W = 16,
  parameter int DEC_W = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  active_i,
  input  logic                                  rd_stb_i,
  input  logic                                  wr_stb_i,
  input  logic [LANES*LVL_W-1:0]                lanes_i,
  input  logic [LANES*LANES*(MAG_W+2)-1:0]      weights_i,
  input  logic signed [ACC_W-1:0]               thr_lo_i,
  input  logic signed [ACC_W-1:0]               thr_hi_i,
  input  logic [DEC_W-1:0]                      decay_i,
  input  logic                                  bus_r_i,
  input  logic                                  bus_w_i,
  output logic                                  locked_o,
  output logic                                  lock_next_o,
  output logic                                  bus_en_o,
  output logic [LANES*LVL_W-1:0]                drive_o,
  output logic signed [ACC_W-1:0]               potential_o
);

  localparam int WGT_W = MAG_W + 2;
  localparam int ROW_W = LVL_W + MAG_W + $clog2(LANES) + 1;
  localparam int TOT_W = ROW_W + $clog2(LANES);

  // Named internal events, visible to the assertions below.
  logic [LANES*ROW_W-1:0]  row_sums;
  logic signed [TOT_W-1:0] row_total;
  logic [LANES*LVL_W-1:0]  lane_levels;
  logic signed [ACC_W-1:0] pot_summed;
  logic signed [ACC_W-1:0] pot_next;
  logic                    window_hit;

  logic signed [ACC_W-1:0] pot_q;
  logic                    pend_q;
  logic                    locked_q;
  logic [LANES*LVL_W-1:0]  drive_q;

  tile_xbar #(
    .LANES(LANES), .LVL_W(LVL_W), .MAG_W(MAG_W),
    .WGT_W(WGT_W), .ROW_W(ROW_W), .TOT_W(TOT_W)
  ) u_xbar (
    .lanes_i (lanes_i),
    .wts_i   (weights_i),
    .rows_o  (row_sums),
    .total_o (row_total)
  );

  tile_quant #(
    .LANES(LANES), .LVL_W(LVL_W), .ROW_W(ROW_W)
  ) u_quant (
    .rows_i   (row_sums),
    .levels_o (lane_levels)
  );

  tile_potential #(
    .ACC_W(ACC_W), .TOT_W(TOT_W), .DEC_W(DEC_W)
  ) u_pot (
    .pot_i    (pot_q),
    .total_i  (row_total),
    .decay_i  (decay_i),
    .summed_o (pot_summed),
    .next_o   (pot_next)
  );

  // Lock test runs on the decayed value (add, then decay, then test).
  assign window_hit = tile_pkg::in_window(int'(pot_next), int'(thr_lo_i), int'(thr_hi_i));

  always_ff @(posedge clk) begin
    if (!rst_n || !active_i) begin
      pot_q    <= '0;
      pend_q   <= 1'b0;
      locked_q <= 1'b0;
      drive_q  <= '0;
    end else begin
      if (rd_stb_i) begin
        pot_q   <= pot_next;
        pend_q  <= window_hit;
        drive_q <= bus_r_i ? lane_levels : '0;
      end
      if (wr_stb_i) begin
        locked_q <= pend_q;
      end
    end
  end

  assign potential_o = pot_q;
  assign lock_next_o = pend_q;
  assign locked_o    = locked_q;
  assign drive_o     = drive_q;
  assign bus_en_o    = bus_w_i & locked_q;

  // R9: inactive tile is cleared on the next clock
  p_inactive_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (potential_o == '0 && !locked_o && !lock_next_o && drive_o == '0));

  // R10: committed lock only moves on a write strobe
  p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !wr_stb_i) |=> $stable(locked_o));

  // R10: write strobe commits the pending value
  p_lock_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && wr_stb_i) |=> (locked_o == $past(lock_next_o)));

  // R12: potential holds without a read strobe
  p_pot_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !rd_stb_i) |=> $stable(potential_o));

  // R4: decay never flips a positive sum negative
  p_decay_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && rd_stb_i && pot_summed > 0) |=> (potential_o >= 0));

  // R4: decay never flips a negative sum positive
  p_decay_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && rd_stb_i && pot_summed < 0) |=> (potential_o <= 0));

  // R8: bus reading disabled gives an empty drive vector
  p_drive_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && rd_stb_i && !bus_r_i) |=> (drive_o == '0));

  // R6: equal thresholds never lock
  p_empty_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && rd_stb_i && thr_lo_i == thr_hi_i) |=> !lock_next_o);

endmodule

// File: tb/sim_crossbar_tile.sv
`timescale 1ns/1ps
module sim_crossbar_tile;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic rst_n = 1'b0;
  logic active = 1'b0;
  logic rd = 1'b0;
  logic wr = 1'b0;
  logic [3:0] lv [8];
  logic [4:0] wt [8][8];
  logic [31:0] lflat;
  logic [319:0] wflat;
  logic signed [15:0] lo = '0;
  logic signed [15:0] hi = '0;
  logic [15:0] dec = '0;
  logic bus_r = 1'b1;
  logic bus_w = 1'b0;

  logic locked, pend, bus_en;
  logic [31:0] drive;
  logic signed [15:0] pot;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  int m_pot, m_pend, m_lck;
  int m_drv [8];

  always_comb begin
    for (int i = 0; i < 8; i++) lflat[i*4 +: 4] = lv[i];
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 8; i++) wflat[(r*8+i)*5 +: 5] = wt[r][i];
  end

  crossbar_tile u0 (
    .clk(clk), .rst_n(rst_n), .active_i(active), .rd_stb_i(rd), .wr_stb_i(wr),
    .lanes_i(lflat), .weights_i(wflat), .thr_lo_i(lo), .thr_hi_i(hi), .decay_i(dec),
    .bus_r_i(bus_r), .bus_w_i(bus_w), .locked_o(locked), .lock_next_o(pend),
    .bus_en_o(bus_en), .drive_o(drive), .potential_o(pot)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bench view of the weight code: bit3 = positive, bits2:0 = magnitude.
  function automatic int b_w(input logic [4:0] c);
    int m;
    m = int'(c[2:0]);
    return c[3] ? m : -m;
  endfunction

  function automatic int b_row(input int r);
    int s;
    s = 0;
    for (int i = 0; i < 8; i++) s += int'(lv[i]) * b_w(wt[r][i]);
    return s;
  endfunction

  function automatic int b_lvl(input int s);
    int q;
    if (s < 0) return 0;
    q = (s + 7) / 8;
    return (q > 15) ? 15 : q;
  endfunction

  task automatic zero_cfg();
    for (int r = 0; r < 8; r++) begin
      lv[r] = '0;
      for (int i = 0; i < 8; i++) wt[r][i] = '0;
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " potential"}, int'(pot), m_pot);
    chk({tag, " pending"}, int'(pend), m_pend);
    chk({tag, " locked"}, int'(locked), m_lck);
    for (int r = 0; r < 8; r++) chk({tag, " drive"}, int'(drive[r*4 +: 4]), m_drv[r]);
  endtask

  task automatic step_read(input string tag);
    int s;
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    if (active) begin
      s = m_pot;
      for (int r = 0; r < 8; r++) s += b_row(r);
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      if (s > 0) s = (s - int'(dec) < 0) ? 0 : s - int'(dec);
      else if (s < 0) s = (s + int'(dec) > 0) ? 0 : s + int'(dec);
      m_pot = s;
      m_pend = (lo != hi && int'(lo) <= s && s <= int'(hi)) ? 1 : 0;
      for (int r = 0; r < 8; r++) m_drv[r] = bus_r ? b_lvl(b_row(r)) : 0;
    end else begin
      m_pot = 0; m_pend = 0; m_lck = 0;
      for (int r = 0; r < 8; r++) m_drv[r] = 0;
    end
    compare(tag);
  endtask

  task automatic step_write(input string tag);
    @(negedge clk) wr = 1'b1;
    @(negedge clk) wr = 1'b0;
    m_lck = m_pend;
    chk({tag, " commit"}, int'(locked), m_lck);
  endtask

  task automatic clear_tile();
    @(negedge clk) active = 1'b0;
    @(negedge clk) active = 1'b1;
    m_pot = 0; m_pend = 0; m_lck = 0;
    for (int r = 0; r < 8; r++) m_drv[r] = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1; active = 1'b1;
    @(negedge clk);
    m_pot = 0; m_pend = 0; m_lck = 0;
    for (int r = 0; r < 8; r++) m_drv[r] = 0;
    compare("reset");
    chk("reset bus_en", int'(bus_en), 0);
  endtask

  task automatic t_basic();   // R1 R2 R7
    clear_tile();
    zero_cfg();
    lo = 0; hi = 0; dec = 0; bus_r = 1;
    wt[0][0] = 5'b01011;  // +3
    wt[0][1] = 5'b00010;  // -2
    wt[1][2] = 5'b01111;  // +7
    lv[0] = 15; lv[1] = 10; lv[2] = 9;
    step_read("R2 mac");
    chk("R2 total", int'(pot), 88);
    chk("R7 lane0", int'(drive[3:0]), 4);
    chk("R7 lane1", int'(drive[7:4]), 8);
    wt[0][0] = 5'b11011;  // reserved bit set, still +3
    step_read("R1 reserved");
    chk("R1 reserved bit", int'(pot), 176);
  endtask

  task automatic t_saturate();  // R3
    clear_tile();
    zero_cfg();
    dec = 0;
    for (int r = 0; r < 8; r++) begin
      lv[r] = 15;
      for (int i = 0; i < 8; i++) wt[r][i] = 5'b01111;
    end
    for (int k = 0; k < 5; k++) step_read("R3 up");
    chk("R3 top", int'(pot), 32767);
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 8; i++) wt[r][i] = 5'b00111;
    for (int k = 0; k < 11; k++) step_read("R3 down");
    chk("R3 bottom", int'(pot), -32768);
  endtask

  task automatic t_decay();  // R4 R5
    clear_tile();
    zero_cfg();
    wt[0][0] = 5'b01100; lv[0] = 5;  // +20
    dec = 10; lo = 5; hi = 12;
    step_read("R5 order");
    chk("R5 add then decay", int'(pot), 10);
    chk("R5 lock on decayed", int'(pend), 1);
    step_write("R5");
    lv[0] = 0; dec = 30;
    step_read("R4 locked decay");
    chk("R4 no crossing", int'(pot), 0);
    clear_tile();
    wt[0][0] = 5'b00100; lv[0] = 5; dec = 0;  // -20
    step_read("R4 neg");
    lv[0] = 0; dec = 5;
    step_read("R4 neg decay");
    chk("R4 rise", int'(pot), -15);
    dec = 30;
    step_read("R4 neg stop");
    chk("R4 neg stop", int'(pot), 0);
  endtask

  task automatic t_window();  // R6 R10 R11
    clear_tile();
    zero_cfg();
    dec = 0; lo = -5; hi = 3; bus_w = 1;
    wt[0][0] = 5'b01001; lv[0] = 3;
    step_read("R6 hi edge");
    chk("R6 hi inclusive", int'(pend), 1);
    chk("R10 not yet", int'(locked), 0);
    chk("R11 off", int'(bus_en), 0);
    step_write("R10");
    chk("R11 on", int'(bus_en), 1);
    lv[0] = 1;
    step_read("R6 above");
    chk("R10 held", int'(locked), 1);
    step_write("R10 drop");
    chk("R11 drop", int'(bus_en), 0);
    clear_tile();
    wt[0][0] = 5'b00001; lv[0] = 5;
    step_read("R6 lo edge");
    chk("R6 lo inclusive", int'(pend), 1);
    lv[0] = 1;
    step_read("R6 below");
    chk("R6 below", int'(pend), 0);
    lo = -6; hi = -6; lv[0] = 0;
    step_read("R6 empty");
    chk("R6 equal bounds", int'(pend), 0);
    bus_w = 0;
  endtask

  task automatic t_drive();  // R7 R8
    clear_tile();
    zero_cfg();
    dec = 0; lo = 0; hi = 0; bus_r = 1;
    lv[0] = 15; lv[1] = 1; lv[2] = 8;
    wt[0][0] = 5'b01001; wt[0][1] = 5'b00111;                      // 8
    wt[1][0] = 5'b01001; wt[1][1] = 5'b00110;                      // 9
    wt[2][0] = 5'b00111; wt[2][1] = 5'b01101;                      // -100
    wt[3][0] = 5'b01111; wt[3][1] = 5'b01111; wt[3][2] = 5'b01001; // 120
    wt[4][0] = 5'b01111; wt[4][2] = 5'b01010;                      // 121
    wt[5][1] = 5'b01001;                                           // 1
    wt[7][0] = 5'b01011; wt[7][1] = 5'b01101;                      // 50
    step_read("R7 levels");
    chk("R7 8", int'(drive[3:0]), 1);
    chk("R7 9", int'(drive[7:4]), 2);
    chk("R7 neg", int'(drive[11:8]), 0);
    chk("R7 120", int'(drive[15:12]), 15);
    chk("R7 121", int'(drive[19:16]), 15);
    chk("R7 50", int'(drive[31:28]), 7);
    chk("R2 sum", int'(pot), 209);
    bus_r = 0;
    step_read("R8 off");
    chk("R8 pot still adds", int'(pot), 418);
    bus_r = 1;
  endtask

  task automatic t_hold();  // R12
    lv[0] = 3; lv[5] = 9;
    repeat (5) @(negedge clk);
    compare("R12 hold");
  endtask

  task automatic t_inactive();  // R9
    bus_w = 1;
    @(negedge clk) active = 1'b0;
    step_read("R9 inactive");
    chk("R9 bus_en", int'(bus_en), 0);
    active = 1'b1; bus_w = 0;
  endtask

  initial begin
    zero_cfg();
    t_reset();
    t_basic();
    t_saturate();
    t_decay();
    t_window();
    t_drive();
    t_hold();
    t_inactive();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

endmodule